// File: doc/BRIEF.md
# Binary Extension Field Multiply-Add Unit

This unit computes `(A * B mod P) XOR C`, where A, B and C are elements of the binary extension field GF(2^m) packed as polynomial coefficient bits (bit i holds the coefficient of x^i). The reducing polynomial P is set through a configuration write port. The degree m and the full polynomial are decoded once per write and kept in internal state, so the degree is not worked out again for each operation.

The configuration value uses a compact encoding. A clear LSB selects degree XLEN, with an implied top coefficient at bit XLEN. This is possible because an irreducible polynomial of degree above 1 always has a constant term. Operands must already be reduced, meaning each is below 2^m.

An operation starts with a one-cycle `start` while the unit is idle. The multiplier is consumed one bit per clock, using shift-and-add with conditional reduction of the multiplicand. `done` pulses for one cycle when `result` is updated. `result` keeps its value until the next `done`.

Top module: `gf2m_madd`

## Requirements
- R1: After reset `busy`, `done` and `result` are 0, and the stored polynomial is x (degree 1), the same as writing the value 0.
- R2: Configuration values 0 and 2 both select the degree-1 polynomial x, so the product is `A[0] & B[0]`.
- R3: For a configuration value with bit 0 set, the degree is the index of its highest set bit and the polynomial is the value itself (for example 0x11B gives degree 8).
- R4: For a configuration value other than 0 or 2 with bit 0 clear, the degree is XLEN and the polynomial is x^XLEN plus the value with bit 0 forced to 1.
- R5: `result` equals the field product of `op_a` and `op_b` reduced modulo the stored polynomial, XORed bitwise with `op_c`. With reduced operands, only bits below the degree can be set.
- R6: `start` is accepted only when `busy` is low. `done` rises XLEN+1 clock cycles after the cycle in which `start` was accepted, and stays high for exactly one cycle.
- R7: `start` is ignored while `busy` is high, and the operation in flight completes with its original operands.
- R8: `cfg_we` is ignored while `busy` is high. Such a write changes neither the current result nor later operations.
- R9: `result` changes only in the cycle in which `done` is high.
- R10: With polynomial 0b1011, 0b111 times 0b101 gives 0b110. With polynomial 0x11B, 0x80 times 0x83 gives 0x01.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the reducing-polynomial register |
| cfg_poly | input | XLEN | Encoded reducing polynomial |
| start | input | 1 | Begin an operation when idle |
| op_a | input | XLEN | Multiplicand |
| op_b | input | XLEN | Multiplier |
| op_c | input | XLEN | Addend |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when the result is updated |
| result | output | XLEN | Last completed result |

## Verification
A wrongly decoded degree or polynomial is first seen at the ports in the `result` of the next operation. It shows up only when a product crosses the degree boundary, so the vectors deliberately push the multiplicand past bit m, including at m = 63 and m = XLEN. A fault in the step counter or in the busy tracking moves `done` away from XLEN+1 cycles after `start`. A start or configuration write that leaks through while busy corrupts the result that is delivered XLEN+1 cycles later, or the result of the operation after it.

// File: rtl/gf2m_madd.sv
module gf2m_madd #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [XLEN-1:0] cfg_poly,
  input  logic            start,
  input  logic [XLEN-1:0] op_a,
  input  logic [XLEN-1:0] op_b,
  input  logic [XLEN-1:0] op_c,
  output logic            busy,
  output logic            done,
  output logic [XLEN-1:0] result
);
  localparam int DW = $clog2(XLEN + 1);

  logic [XLEN:0]   poly_q, dec_poly;
  logic [DW-1:0]   deg_q, dec_deg, cnt_q;
  logic [XLEN:0]   a_q, a_sh, a_nx;
  logic [XLEN-1:0] b_q, c_q, acc_q, acc_nx, res_q;
  logic            busy_q, done_q;

  always_comb begin
    dec_deg  = DW'(1);
    dec_poly = (XLEN+1)'(2);
    if (cfg_poly != '0 && cfg_poly != XLEN'(2)) begin
      if (!cfg_poly[0]) begin
        dec_deg  = DW'(XLEN);
        dec_poly = {1'b1, cfg_poly[XLEN-1:1], 1'b1};
      end else begin
        dec_poly = {1'b0, cfg_poly};
        for (int i = 0; i < XLEN; i++)
          if (cfg_poly[i]) dec_deg = DW'(i);
      end
    end
  end

  assign acc_nx = b_q[0] ? (acc_q ^ a_q[XLEN-1:0]) : acc_q;
  assign a_sh   = {a_q[XLEN-1:0], 1'b0};
  assign a_nx   = a_sh[deg_q] ? (a_sh ^ poly_q) : a_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      poly_q <= (XLEN+1)'(2);
      deg_q  <= DW'(1);
      a_q    <= '0;
      b_q    <= '0;
      c_q    <= '0;
      acc_q  <= '0;
      res_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (cfg_we) begin
          poly_q <= dec_poly;
          deg_q  <= dec_deg;
        end
        if (start) begin
          a_q    <= {1'b0, op_a};
          b_q    <= op_b;
          c_q    <= op_c;
          acc_q  <= '0;
          cnt_q  <= '0;
          busy_q <= 1'b1;
        end
      end else begin
        acc_q <= acc_nx;
        a_q   <= a_nx;
        b_q   <= b_q >> 1;
        cnt_q <= cnt_q + DW'(1);
        if (cnt_q == DW'(XLEN - 1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          res_q  <= acc_nx ^ c_q;
        end
      end
    end
  end

  assign busy   = busy_q;
  assign done   = done_q;
  assign result = res_q;
endmodule

// File: rtl/gf2m_madd_chk.sv
module gf2m_madd_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            busy,
  input logic            done,
  input logic [XLEN-1:0] result
);
  logic [31:0] lat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              lat_q <= '0;
    else if (!busy && start) lat_q <= 32'd1;
    else if (busy)           lat_q <= lat_q + 32'd1;
  end

  a_r6_start_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy);
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r6_latency: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lat_q == 32'(XLEN + 1)));
  a_r7_busy_until_done: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy || done));
  a_r9_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));
endmodule

bind gf2m_madd gf2m_madd_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start),
  .busy(busy), .done(done), .result(result)
);

// File: tb/gf2m_madd_bench.sv
module gf2m_madd_bench;
  localparam int XLEN = 64;
  localparam int NV = 10;

  // R2, R3, R4, R5, R10 vectors: polynomial, a, b, c, expected
  localparam logic [63:0] V_POLY[NV] = '{64'hB, 64'h11B, 64'h11B, 64'h11B, 64'h11B,
    64'h0, 64'h2, 64'h13, 64'h4, 64'h8000_0000_0000_001B};
  localparam logic [63:0] V_A[NV] = '{64'h7, 64'h80, 64'h80, 64'h57, 64'h57,
    64'h1, 64'h1, 64'h2, 64'h8000_0000_0000_0000, 64'h4000_0000_0000_0000};
  localparam logic [63:0] V_B[NV] = '{64'h5, 64'h83, 64'h83, 64'h83, 64'h13,
    64'h1, 64'h0, 64'h8, 64'h2, 64'h2};
  localparam logic [63:0] V_C[NV] = '{64'h0, 64'h0, 64'h55, 64'h0, 64'h0,
    64'h0, 64'h1, 64'h0, 64'h0, 64'h0};
  localparam logic [63:0] V_EXP[NV] = '{64'h6, 64'h01, 64'h54, 64'hC1, 64'hFE,
    64'h1, 64'h1, 64'h3, 64'h5, 64'h1B};

  logic clk = 0, rst_n = 0, cfg_we = 0, start = 0;
  logic [XLEN-1:0] cfg_poly = '0, op_a = '0, op_b = '0, op_c = '0;
  logic busy, done;
  logic [XLEN-1:0] result;
  int n_run = 0, n_fail = 0;

  gf2m_madd #(.XLEN(XLEN)) u_gf2m_madd (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_poly(cfg_poly),
    .start(start), .op_a(op_a), .op_b(op_b), .op_c(op_c),
    .busy(busy), .done(done), .result(result)
  );

  always #2 clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_poly(input logic [63:0] v);
    @(negedge clk); cfg_we = 1; cfg_poly = v;
    @(negedge clk); cfg_we = 0;
  endtask

  // inject: 0 none, 1 start mid-op, 2 cfg write mid-op
  task automatic run_op(input logic [63:0] a, input logic [63:0] b, input logic [63:0] c,
                        input int inject, output logic [63:0] res, output int lat);
    @(negedge clk); start = 1; op_a = a; op_b = b; op_c = c;
    lat = 0;
    forever begin
      @(negedge clk); lat++;
      if (lat == 1) start = 0;
      if (lat == 5 && inject == 1) begin start = 1; op_a = '1; op_b = '1; op_c = '1; end
      if (lat == 6) start = 0;
      if (lat == 3 && inject == 2) begin cfg_we = 1; cfg_poly = 64'h13; end
      if (lat == 4) cfg_we = 0;
      if (done || lat > 3 * XLEN) break;
    end
    res = result;
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] r, keep;
    int lat;
    repeat (3) @(negedge clk);
    check("R1 busy", 64'(busy), 64'h0);
    check("R1 done", 64'(done), 64'h0);
    check("R1 result", result, 64'h0);
    rst_n = 1;
    @(negedge clk);
    run_op(64'h1, 64'h1, 64'h0, 0, r, lat);
    check("R1 reset poly", r, 64'h1);

    for (int i = 0; i < NV; i++) begin
      write_poly(V_POLY[i]);
      run_op(V_A[i], V_B[i], V_C[i], 0, r, lat);
      check($sformatf("R5 vector %0d", i), r, V_EXP[i]);
      check("R6 latency", 64'(lat), 64'(XLEN + 1));
    end

    @(negedge clk);
    check("R6 done one cycle", 64'(done), 64'h0);
    check("R6 busy low", 64'(busy), 64'h0);

    write_poly(64'h11B);
    run_op(64'h57, 64'h83, 64'h0, 1, r, lat);
    check("R7 start ignored", r, 64'hC1);
    check("R7 latency", 64'(lat), 64'(XLEN + 1));
    keep = r;
    for (int k = 0; k < XLEN + 4; k++) begin
      @(negedge clk);
      if (done) check("R7 no extra done", 64'(done), 64'h0);
    end
    check("R9 result held", result, keep);

    run_op(64'h80, 64'h83, 64'h0, 2, r, lat);
    check("R8 cfg ignored current", r, 64'h01);
    run_op(64'h57, 64'h13, 64'h0, 0, r, lat);
    check("R8 cfg ignored later", r, 64'hFE);

    write_poly(64'hB);
    run_op(64'h4, 64'h4, 64'h1, 0, r, lat);
    check("R10 gf8 x2*x2+1", r, 64'h7);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule